// File: doc/BRIEF.md
# Transmit completion status stack

This block keeps the result of each finished transmission in a small last-in first-out store, which a host reads one byte at a time. When a frame ends, the transmit engine presents one pulse on `frame_done` together with its result bits. The block turns these into a status byte and pushes that byte onto the stack if the result is worth reporting. The host always sees the newest entry on `status_byte`. It removes that entry by pulsing `host_wr`, which stands for a write to the status register.

`tx_complete` tells the command controller that at least one entry is waiting. A jabber or underrun result is fatal. It latches `tx_disabled`, and while that flag is set the block ignores further frame results. Only `tx_reset` clears the flag. The same reset also empties the stack. When the stack is already full, a new result is lost, and the newest stored entry is marked so that the host can tell that entries went missing.

Every state change takes effect at a rising clock edge. The outputs come only from registers, so each one reflects the inputs sampled at the previous edge.

Top module: `tx_status_lifo`

## Requirements
- R1: A stored entry reads as the following byte. Bit 7 = 1 (complete), bit 6 = interrupt-on-success request, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow (0 when pushed), and bits 1..0 = 0.
- R2: A finished frame with any error bit (jabber, underrun, max collisions) is always pushed. A frame with no error is pushed only when its interrupt-on-success request is 1. Otherwise it leaves the stack unchanged.
- R3: The newest entry is shown on `status_byte`. A `host_wr` pulse removes it, so the next-older entry appears after the following clock edge.
- R4: An empty stack reads as 0x00. A `host_wr` on an empty stack changes nothing.
- R5: A push that finds DEPTH entries already stored (default 4) discards the new result and sets bit 2 of the current top entry. All other entries stay unchanged.
- R6: `tx_complete` is 1 exactly when the stack holds at least one entry.
- R7: A frame result with jabber or underrun sets `tx_disabled` at the next edge. The flag stays set until `tx_reset`.
- R8: `tx_reset` empties the stack and clears `tx_disabled`. It overrides a frame result and a `host_wr` in the same cycle.
- R9: While `tx_disabled` is 1, frame results are ignored. They push nothing and mark nothing.
- R10: When `host_wr` and a loggable frame arrive in the same cycle, the pop is applied first and the push second. A full stack therefore takes the new entry with no overflow mark.
- R11: Synchronous active-high `rst` leaves the stack empty (`status_byte` = 0x00, `tx_complete` = 0) and `tx_disabled` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle pulse: a transmission has finished |
| res_irq_ok | input | 1 | Interrupt requested on success for this frame |
| res_jabber | input | 1 | Frame ended with jabber error |
| res_underrun | input | 1 | Frame ended with underrun |
| res_max_coll | input | 1 | Frame hit maximum collisions |
| host_wr | input | 1 | Host write to the status register (pop) |
| tx_reset | input | 1 | Transmit reset command |
| status_byte | output | 8 | Top entry, or 0x00 when empty |
| tx_complete | output | 1 | Stack not empty |
| tx_disabled | output | 1 | Transmitter disabled by a fatal result |

## Verification
The bench fills the stack and pushes once more. A design that overwrites the oldest entry, keeps the new one, or marks the wrong slot shows up as a wrong byte during the pops that follow. It applies a pop and a push in the same cycle, both on a full stack and on an empty one. A design that orders them the other way reports a false overflow or loses the entry. It sends frames while disabled, and frames in the same cycle as a transmit reset. A design that keeps logging after a fatal result, or lets a frame win over the reset, leaves entries or the disable flag behind. A model-driven random run then mixes pops on an empty stack, success frames with and without the interrupt request, and overflows.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int unsigned ENTRY_W = 6;

    // Result bits handed over by the transmit engine for one frame.
    typedef struct packed {
        logic irq_ok;
        logic jabber;
        logic underrun;
        logic max_coll;
    } txs_result_t;

    // One stored entry; the byte seen by the host is this plus two zero bits.
    typedef struct packed {
        logic done;
        logic irq_ok;
        logic jabber;
        logic underrun;
        logic max_coll;
        logic ovf;
    } txs_entry_t;

    function automatic logic is_fatal(input txs_result_t r);
        return r.jabber | r.underrun;
    endfunction

    function automatic logic has_error(input txs_result_t r);
        return r.jabber | r.underrun | r.max_coll;
    endfunction

    function automatic logic wants_log(input txs_result_t r);
        return has_error(r) | r.irq_ok;
    endfunction

    function automatic txs_entry_t make_entry(input txs_result_t r);
        txs_entry_t e;
        e.done     = 1'b1;
        e.irq_ok   = r.irq_ok;
        e.jabber   = r.jabber;
        e.underrun = r.underrun;
        e.max_coll = r.max_coll;
        e.ovf      = 1'b0;
        return e;
    endfunction

    function automatic logic [7:0] entry_byte(input txs_entry_t e);
        return {e, 2'b00};
    endfunction

endpackage

// File: rtl/txs_classify.sv
module txs_classify
    import txs_pkg::*;
(
    input  logic        frame_done,
    input  txs_result_t result,
    input  logic        disabled,
    output logic        push_req,
    output txs_entry_t  push_entry,
    output logic        fatal_hit
);
    logic accepted;

    always_comb begin
        accepted   = frame_done & ~disabled;
        push_req   = accepted & wants_log(result);
        fatal_hit  = accepted & is_fatal(result);
        push_entry = make_entry(result);
    end
endmodule

// File: rtl/txs_guard.sv
module txs_guard (
    input  logic clk,
    input  logic rst,
    input  logic tx_reset,
    input  logic fatal_hit,
    output logic disabled_q
);
    always_ff @(posedge clk) begin
        if (rst || tx_reset) begin
            disabled_q <= 1'b0;
        end else if (fatal_hit) begin
            disabled_q <= 1'b1;
        end
    end
endmodule

// File: rtl/txs_lifo.sv
module txs_lifo
    import txs_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       push,
    input  txs_entry_t push_entry,
    input  logic       pop,
    output logic       top_valid,
    output txs_entry_t top_entry
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] count_q;
    logic [CW-1:0] cnt_after_pop;
    logic          pop_eff;
    logic          full_after_pop;
    logic          push_ok;
    logic          ovf_mark;
    logic [IW-1:0] top_idx;
    txs_entry_t    slot_q [DEPTH];

    always_comb begin
        pop_eff        = pop & (count_q != '0);
        cnt_after_pop  = count_q - CW'(pop_eff);
        full_after_pop = (cnt_after_pop == CW'(DEPTH));
        push_ok        = push & ~full_after_pop;
        ovf_mark       = push & full_after_pop;
        top_idx        = IW'(count_q - CW'(1));
        top_valid      = (count_q != '0);
        top_entry      = top_valid ? slot_q[top_idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else begin
            count_q <= cnt_after_pop + CW'(push_ok);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                slot_q[i] <= '0;
            end else if (push_ok && cnt_after_pop == CW'(i)) begin
                slot_q[i] <= push_entry;
            end else if (ovf_mark && i == DEPTH - 1) begin
                slot_q[i].ovf <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tx_status_lifo.sv
module tx_status_lifo
    import txs_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_done,
    input  logic       res_irq_ok,
    input  logic       res_jabber,
    input  logic       res_underrun,
    input  logic       res_max_coll,
    input  logic       host_wr,
    input  logic       tx_reset,
    output logic [7:0] status_byte,
    output logic       tx_complete,
    output logic       tx_disabled
);
    txs_result_t result;
    txs_entry_t  push_entry;
    txs_entry_t  top_entry;
    logic        push_req;
    logic        fatal_hit;
    logic        disabled_q;
    logic        top_valid;

    always_comb begin
        result.irq_ok   = res_irq_ok;
        result.jabber   = res_jabber;
        result.underrun = res_underrun;
        result.max_coll = res_max_coll;
    end

    txs_classify u_classify (
        .frame_done (frame_done),
        .result     (result),
        .disabled   (disabled_q),
        .push_req   (push_req),
        .push_entry (push_entry),
        .fatal_hit  (fatal_hit)
    );

    txs_guard u_guard (
        .clk        (clk),
        .rst        (rst),
        .tx_reset   (tx_reset),
        .fatal_hit  (fatal_hit),
        .disabled_q (disabled_q)
    );

    txs_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk        (clk),
        .rst        (rst),
        .clear      (tx_reset),
        .push       (push_req),
        .push_entry (push_entry),
        .pop        (host_wr),
        .top_valid  (top_valid),
        .top_entry  (top_entry)
    );

    always_comb begin
        status_byte = entry_byte(top_entry);
        tx_complete = top_valid;
        tx_disabled = disabled_q;
    end
endmodule

// File: rtl/tx_status_lifo_chk.sv
module tx_status_lifo_chk (
    input logic       clk,
    input logic       rst,
    input logic       frame_done,
    input logic       res_jabber,
    input logic       res_underrun,
    input logic       host_wr,
    input logic       tx_reset,
    input logic [7:0] status_byte,
    input logic       tx_complete,
    input logic       tx_disabled
);
    p_empty_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !tx_complete |-> status_byte == 8'h00);

    p_entry_format_r1: assert property (@(posedge clk) disable iff (rst)
        tx_complete |-> (status_byte[7] && status_byte[1:0] == 2'b00));

    p_empty_pop_noop_r4: assert property (@(posedge clk) disable iff (rst)
        (!tx_complete && !frame_done && !tx_reset) |=> !tx_complete);

    p_fatal_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !tx_disabled && (res_jabber || res_underrun) && !tx_reset)
        |=> tx_disabled);

    p_disable_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_disabled && !tx_reset) |=> tx_disabled);

    p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
        tx_reset |=> (!tx_complete && !tx_disabled));

    p_disabled_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_disabled && !host_wr && !tx_reset) |=> $stable(status_byte));

    p_overflow_from_frame_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(status_byte[2]) |-> $past(frame_done));
endmodule

bind tx_status_lifo tx_status_lifo_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_done   (frame_done),
    .res_jabber   (res_jabber),
    .res_underrun (res_underrun),
    .host_wr      (host_wr),
    .tx_reset     (tx_reset),
    .status_byte  (status_byte),
    .tx_complete  (tx_complete),
    .tx_disabled  (tx_disabled)
);

// File: tb/test_tx_status_lifo.sv
`timescale 1ns/1ps
module test_tx_status_lifo;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_done = 1'b0;
    logic       res_irq_ok = 1'b0;
    logic       res_jabber = 1'b0;
    logic       res_underrun = 1'b0;
    logic       res_max_coll = 1'b0;
    logic       host_wr = 1'b0;
    logic       tx_reset = 1'b0;
    logic [7:0] status_byte;
    logic       tx_complete;
    logic       tx_disabled;

    always #2.5 clk = ~clk;

    tx_status_lifo #(.DEPTH(DEPTH)) i_tx_status_lifo (
        .clk          (clk),
        .rst          (rst),
        .frame_done   (frame_done),
        .res_irq_ok   (res_irq_ok),
        .res_jabber   (res_jabber),
        .res_underrun (res_underrun),
        .res_max_coll (res_max_coll),
        .host_wr      (host_wr),
        .tx_reset     (tx_reset),
        .status_byte  (status_byte),
        .tx_complete  (tx_complete),
        .tx_disabled  (tx_disabled)
    );

    typedef struct {
        logic [7:0] st;
        logic       ev;
        logic       dis;
        string      tag;
    } exp_t;

    exp_t       expq[$];
    logic [7:0] mstk[$];
    bit         mdis = 1'b0;
    int         nvec = 0;
    int         nbad = 0;
    bit         done = 1'b0;

    function automatic void push_exp(input string tag);
        exp_t e;
        e.st  = (mstk.size() > 0) ? mstk[mstk.size()-1] : 8'h00;
        e.ev  = (mstk.size() > 0);
        e.dis = mdis;
        e.tag = tag;
        expq.push_back(e);
    endfunction

    // Monitor: compares one expectation per falling edge.
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            nvec++;
            if (status_byte !== e.st || tx_complete !== e.ev || tx_disabled !== e.dis) begin
                nbad++;
                $display("FAIL %s: status=%h cmp=%b dis=%b expected status=%h cmp=%b dis=%b",
                         e.tag, status_byte, tx_complete, tx_disabled, e.st, e.ev, e.dis);
            end
        end
    end

    // Driver: applies one cycle of stimulus, updates the model, queues the result.
    task automatic step(input bit fd, input bit irq, input bit jab, input bit und,
                        input bit mc, input bit wr, input bit trst, input string tag);
        @(negedge clk);
        frame_done = fd; res_irq_ok = irq; res_jabber = jab;
        res_underrun = und; res_max_coll = mc; host_wr = wr; tx_reset = trst;
        @(posedge clk);
        if (trst) begin
            mstk.delete();
            mdis = 1'b0;
        end else begin
            if (wr && mstk.size() > 0) void'(mstk.pop_back());
            if (fd && !mdis) begin
                if (jab || und || mc || irq) begin
                    if (mstk.size() < DEPTH)
                        mstk.push_back({1'b1, irq, jab, und, mc, 3'b000});
                    else
                        mstk[mstk.size()-1][2] = 1'b1;
                end
                if (jab || und) mdis = 1'b1;
            end
        end
        #1;
        push_exp(tag);
    endtask

    task automatic frame(input bit irq, input bit jab, input bit und, input bit mc,
                         input string tag);
        step(1, irq, jab, und, mc, 0, 0, tag);
    endtask

    task automatic pop(input string tag);
        step(0, 0, 0, 0, 0, 1, 0, tag);
    endtask

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        #1;
        push_exp("R11 reset state");
        @(negedge clk);
        rst = 1'b0;

        // R2: success without request is not logged; R1 format 0xC0
        frame(0, 0, 0, 0, "R2 success without request ignored");
        frame(1, 0, 0, 0, "R1 R2 success with request 0xC0");
        frame(0, 0, 0, 1, "R1 R2 max collision 0x88");
        pop("R3 pop reveals older entry");
        pop("R4 pop to empty");
        pop("R4 pop of empty stack");

        // R5: fill then overflow
        frame(1, 0, 0, 0, "R6 fill 1");
        frame(0, 0, 0, 1, "R6 fill 2");
        frame(1, 0, 0, 1, "R6 fill 3");
        frame(1, 0, 0, 0, "R6 fill 4");
        frame(0, 0, 0, 1, "R5 overflow marks top");
        pop("R5 entry below unchanged");
        // R10: pop and push together on a nearly full stack
        frame(1, 0, 0, 0, "R6 refill to full");
        step(1, 0, 0, 0, 1, 1, 0, "R10 pop then push when full");
        pop("R3 pop after combined");
        pop("R3 pop");
        pop("R3 pop");
        pop("R4 pop to empty");
        step(1, 1, 0, 0, 0, 1, 0, "R10 pop and push on empty");
        pop("R4 empty again");

        // R7/R9/R8
        frame(0, 0, 1, 0, "R7 underrun disables 0x90");
        frame(0, 0, 0, 1, "R9 frame ignored while disabled");
        frame(0, 1, 0, 0, "R9 jabber ignored while disabled");
        pop("R7 disable holds across pop");
        step(1, 0, 1, 0, 0, 1, 1, "R8 reset beats frame and pop");
        frame(1, 1, 0, 0, "R7 jabber disables 0xE0");
        frame(1, 0, 0, 0, "R6 push while disabled");
        step(0, 0, 0, 0, 0, 0, 1, "R8 reset clears stack and disable");
        step(0, 0, 0, 0, 0, 0, 0, "R6 idle after reset");

        // Random run against the model
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r < 55, $urandom_range(0, 1), $urandom_range(0, 19) == 0,
                 $urandom_range(0, 19) == 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 99) < 40, $urandom_range(0, 39) == 0,
                 "R3 R5 R10 random sequence");
        end

        step(0, 0, 0, 0, 0, 0, 0, "R6 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule